// File: doc/BRIEF.md
# Stateful Port-Knocking Flow Filter

This block decides, packet by packet, whether traffic from a source host may pass. Each packet offered on the input carries a 32-bit source IPv4 address and a 16-bit destination port. The block returns a forward or drop verdict. A host earns access to a protected service port by first sending packets to four secret ports in a fixed order. Until it has done so, all of its traffic is dropped.

Per-host progress is kept in a small associative table keyed by source address. Each entry holds a valid bit, the address and a 3-bit flow state. A single transition table, shared by every host, maps the pair (current state, destination port) to a verdict and a next state.

The block handles each packet in three steps:

1. It looks up the state during the acceptance cycle.
2. It applies the transition in the following cycle.
3. It writes the next state back under the same address at the end of that cycle.

If a packet of the same host, or a packet that hits an entry being evicted, is accepted while an earlier packet is between lookup and write-back, the freshly computed result is forwarded to it. It never sees the stale table contents.

The states are:

| State | Code | Meaning |
|---|---|---|
| `ST_IDLE` | 0 | The host has made no progress. This is the state of any host without an entry. |
| `ST_K1` | 1 | First knock received. |
| `ST_K2` | 2 | Second knock received. |
| `ST_K3` | 3 | Third knock received. |
| `ST_OPEN` | 4 | Access granted. |

The knock ports are, in order, 5123, 6234, 7345 and 8456. The service port is 22.

The transitions are:

- **advance**: `ST_IDLE`→`ST_K1` on 5123, `ST_K1`→`ST_K2` on 6234, `ST_K2`→`ST_K3` on 7345, `ST_K3`→`ST_OPEN` on 8456. Every advance drops the packet.
- **fallback**: in any of `ST_IDLE`, `ST_K1`, `ST_K2` or `ST_K3`, any other port drops the packet and returns the host to `ST_IDLE`.
- **serve**: `ST_OPEN` on port 22 forwards the packet and stays in `ST_OPEN`.
- **hold**: `ST_OPEN` on any other port drops the packet and stays in `ST_OPEN`.

Top module: `knock_filter`

## Requirements
- R1: A packet is accepted when `pkt_valid` and `pkt_ready` are both high at a rising edge. Its verdict is presented with `dec_valid` high after exactly the second rising edge following acceptance. `pkt_ready` rises at the first edge after reset is released and then stays high, so one packet can be accepted every cycle.
- R2: While `rst_n` is low, `dec_valid` and `pkt_ready` are 0 and the table is emptied, so after reset every host is in `ST_IDLE` (code 0).
- R3: The knocks 5123, 6234, 7345 and 8456, sent in that order, move a host through `ST_IDLE`(0), `ST_K1`(1), `ST_K2`(2), `ST_K3`(3) and then `ST_OPEN`(4). Every knock packet gets `dec_forward`=0 (drop).
- R4: In `ST_OPEN`, a packet to port 22 gets `dec_forward`=1 (forward) and the host stays in `ST_OPEN`. A packet to any other port gets `dec_forward`=0 and the host still stays in `ST_OPEN`.
- R5: In any state other than `ST_OPEN`, a port other than the expected next knock gives `dec_forward`=0 and returns the host to `ST_IDLE`.
- R6: A source address with no entry behaves as `ST_IDLE`. Each host's progress is independent of all others, even when their packets are interleaved.
- R7: A packet from a host without an entry whose next state is `ST_IDLE` allocates nothing. An entry is allocated only when a host leaves `ST_IDLE`, and it takes the lowest-numbered empty entry (entries 0 to 15).
- R8: When all 16 entries are in use, a new host takes the entry selected by a round-robin pointer. The pointer starts at entry 0 after reset and advances by one, modulo 16, after each eviction. The evicted host is then treated as `ST_IDLE`.
- R9: Two back-to-back packets of the same host are handled as if sequential: the second uses the state computed for the first. A packet that hits an entry being evicted by the packet one cycle ahead of it is treated as having no entry.
- R10: `dec_forward` is 0 whenever `dec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | A packet is offered |
| pkt_ready | output | 1 | The block can take a packet this cycle |
| pkt_src_addr | input | 32 | Source IPv4 address, used as the flow key |
| pkt_dst_port | input | 16 | Destination TCP/UDP port |
| dec_valid | output | 1 | A verdict is presented |
| dec_forward | output | 1 | 1 = forward, 0 = drop |

## Verification
Every verdict is due two rising edges after its packet is accepted: one edge loads the lookup stage and the next loads the verdict register. The bench therefore pushes the expected verdict of each accepted packet into a two-deep shift register clocked on the rising edge. It compares `dec_valid` and `dec_forward` against the far end of that register at every falling edge, so a verdict one cycle early or late is caught in every cycle. Streams of packets sent back-to-back exercise the forwarding path in the very cycle the write-back is still pending. Eviction is checked by a packet that follows its evictor by exactly one cycle, and also afterwards through the victim's verdict on port 22.

// File: rtl/knock_pkg.sv
package knock_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_K1   = 3'd1,
        ST_K2   = 3'd2,
        ST_K3   = 3'd3,
        ST_OPEN = 3'd4
    } flow_state_e;

endpackage

// File: rtl/knock_transition.sv
// Shared transition table: (state, port) -> (next state, verdict).
module knock_transition
    import knock_pkg::*;
#(
    parameter int PORT_W       = 16,
    parameter int KNOCK_0      = 5123,
    parameter int KNOCK_1      = 6234,
    parameter int KNOCK_2      = 7345,
    parameter int KNOCK_3      = 8456,
    parameter int SERVICE_PORT = 22
) (
    input  flow_state_e       cur_state,
    input  logic [PORT_W-1:0] dst_port,
    output flow_state_e       next_state,
    output logic              forward
);

    localparam logic [PORT_W-1:0] P_K0  = PORT_W'(KNOCK_0);
    localparam logic [PORT_W-1:0] P_K1  = PORT_W'(KNOCK_1);
    localparam logic [PORT_W-1:0] P_K2  = PORT_W'(KNOCK_2);
    localparam logic [PORT_W-1:0] P_K3  = PORT_W'(KNOCK_3);
    localparam logic [PORT_W-1:0] P_SVC = PORT_W'(SERVICE_PORT);

    always_comb begin
        next_state = ST_IDLE;
        forward    = 1'b0;
        unique case (cur_state)
            ST_IDLE: next_state = (dst_port == P_K0) ? ST_K1   : ST_IDLE;
            ST_K1:   next_state = (dst_port == P_K1) ? ST_K2   : ST_IDLE;
            ST_K2:   next_state = (dst_port == P_K2) ? ST_K3   : ST_IDLE;
            ST_K3:   next_state = (dst_port == P_K3) ? ST_OPEN : ST_IDLE;
            ST_OPEN: begin
                next_state = ST_OPEN;
                forward    = (dst_port == P_SVC);
            end
            default: next_state = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/knock_state_table.sv
// Associative per-flow state store with lowest-free allocation and
// round-robin eviction when full.
module knock_state_table
    import knock_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int KEY_W = 32,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    // lookup
    input  logic [KEY_W-1:0] lk_key,
    output logic             lk_hit,
    output logic [IDX_W-1:0] lk_idx,
    output flow_state_e      lk_state,
    // allocation target
    output logic [IDX_W-1:0] alloc_idx,
    // write-back
    input  logic             wr_en,
    input  logic             wr_alloc,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_key,
    input  flow_state_e      wr_state
);

    logic             ent_vld [DEPTH];
    logic [KEY_W-1:0] ent_key [DEPTH];
    flow_state_e      ent_st  [DEPTH];
    logic [DEPTH-1:0] match_vec;
    logic [IDX_W-1:0] free_idx;
    logic             full;
    logic [IDX_W-1:0] rr_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        assign match_vec[g] = ent_vld[g] && (ent_key[g] == lk_key);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_vld[g] <= 1'b0;
                ent_key[g] <= '0;
                ent_st[g]  <= ST_IDLE;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                ent_vld[g] <= 1'b1;
                ent_key[g] <= wr_key;
                ent_st[g]  <= wr_state;
            end
        end
    end

    always_comb begin
        lk_hit = 1'b0;
        lk_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                lk_hit = 1'b1;
                lk_idx = IDX_W'(i);
            end
        end
        lk_state = lk_hit ? ent_st[lk_idx] : ST_IDLE;
    end

    always_comb begin
        full     = 1'b1;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!ent_vld[i]) begin
                full     = 1'b0;
                free_idx = IDX_W'(i);
            end
        end
        alloc_idx = full ? rr_q : free_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (wr_en && wr_alloc && full) begin
            rr_q <= (rr_q == IDX_W'(DEPTH - 1)) ? '0 : rr_q + 1'b1;
        end
    end

endmodule

// File: rtl/knock_filter.sv
// Two-stage per-flow knock filter: lookup in the accept cycle,
// transition and write-back in the next, verdict registered.
module knock_filter
    import knock_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int KEY_W        = 32,
    parameter int PORT_W       = 16,
    parameter int KNOCK_0      = 5123,
    parameter int KNOCK_1      = 6234,
    parameter int KNOCK_2      = 7345,
    parameter int KNOCK_3      = 8456,
    parameter int SERVICE_PORT = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    output logic              pkt_ready,
    input  logic [KEY_W-1:0]  pkt_src_addr,
    input  logic [PORT_W-1:0] pkt_dst_port,
    output logic              dec_valid,
    output logic              dec_forward
);

    localparam int IDX_W = $clog2(DEPTH);

    // table lookup result (raw)
    logic             tbl_hit;
    logic [IDX_W-1:0] tbl_idx;
    flow_state_e      tbl_state;
    logic [IDX_W-1:0] alloc_idx;

    // lookup result after hazard forwarding
    logic             lk_hit;
    logic [IDX_W-1:0] lk_idx;
    flow_state_e      lk_state;

    // transition stage registers
    logic              s1_valid;
    logic [KEY_W-1:0]  s1_key;
    logic [PORT_W-1:0] s1_port;
    logic              s1_hit;
    logic [IDX_W-1:0]  s1_idx;
    flow_state_e       s1_state;

    flow_state_e      nxt_state;
    logic             nxt_fwd;
    logic             do_write;
    logic [IDX_W-1:0] wr_idx;
    logic             accept;

    assign accept = pkt_valid && pkt_ready;

    knock_state_table #(
        .DEPTH (DEPTH),
        .KEY_W (KEY_W),
        .IDX_W (IDX_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_key    (pkt_src_addr),
        .lk_hit    (tbl_hit),
        .lk_idx    (tbl_idx),
        .lk_state  (tbl_state),
        .alloc_idx (alloc_idx),
        .wr_en     (do_write),
        .wr_alloc  (!s1_hit),
        .wr_idx    (wr_idx),
        .wr_key    (s1_key),
        .wr_state  (nxt_state)
    );

    knock_transition #(
        .PORT_W       (PORT_W),
        .KNOCK_0      (KNOCK_0),
        .KNOCK_1      (KNOCK_1),
        .KNOCK_2      (KNOCK_2),
        .KNOCK_3      (KNOCK_3),
        .SERVICE_PORT (SERVICE_PORT)
    ) u_xfsm (
        .cur_state  (s1_state),
        .dst_port   (s1_port),
        .next_state (nxt_state),
        .forward    (nxt_fwd)
    );

    // write-back: existing entries always updated, new ones only on leaving idle
    assign do_write = s1_valid && (s1_hit || (nxt_state != ST_IDLE));
    assign wr_idx   = s1_hit ? s1_idx : alloc_idx;

    // hazard forwarding past the pending write
    always_comb begin
        lk_hit   = tbl_hit;
        lk_idx   = tbl_idx;
        lk_state = tbl_state;
        if (do_write && (s1_key == pkt_src_addr)) begin
            lk_hit   = 1'b1;
            lk_idx   = wr_idx;
            lk_state = nxt_state;
        end else if (do_write && tbl_hit && (tbl_idx == wr_idx)) begin
            // entry being overwritten by another flow: stale hit
            lk_hit   = 1'b0;
            lk_idx   = '0;
            lk_state = ST_IDLE;
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_key   <= '0;
            s1_port  <= '0;
            s1_hit   <= 1'b0;
            s1_idx   <= '0;
            s1_state <= ST_IDLE;
        end else begin
            s1_valid <= accept;
            if (accept) begin
                s1_key   <= pkt_src_addr;
                s1_port  <= pkt_dst_port;
                s1_hit   <= lk_hit;
                s1_idx   <= lk_idx;
                s1_state <= lk_state;
            end
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_ready   <= 1'b0;
            dec_valid   <= 1'b0;
            dec_forward <= 1'b0;
        end else begin
            pkt_ready   <= 1'b1;
            dec_valid   <= s1_valid;
            dec_forward <= s1_valid && nxt_fwd;
        end
    end

endmodule

// File: rtl/knock_filter_checker.sv
module knock_filter_checker #(
    parameter int PORT_W       = 16,
    parameter int KNOCK_0      = 5123,
    parameter int KNOCK_1      = 6234,
    parameter int KNOCK_2      = 7345,
    parameter int KNOCK_3      = 8456,
    parameter int SERVICE_PORT = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pkt_valid,
    input logic              pkt_ready,
    input logic [PORT_W-1:0] pkt_dst_port,
    input logic              dec_valid,
    input logic              dec_forward
);

    logic              acc_q1, acc_q2;
    logic [PORT_W-1:0] port_q1, port_q2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q1  <= 1'b0;
            acc_q2  <= 1'b0;
            port_q1 <= '0;
            port_q2 <= '0;
        end else begin
            acc_q1  <= pkt_valid && pkt_ready;
            acc_q2  <= acc_q1;
            port_q1 <= pkt_dst_port;
            port_q2 <= port_q1;
        end
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid == acc_q2);

    assert_ready_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pkt_ready) |-> pkt_ready);

    assert_knock_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && ((port_q2 == PORT_W'(KNOCK_0)) || (port_q2 == PORT_W'(KNOCK_1)) ||
                       (port_q2 == PORT_W'(KNOCK_2)) || (port_q2 == PORT_W'(KNOCK_3))))
        |-> !dec_forward);

    assert_fwd_service_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_forward |-> (port_q2 == PORT_W'(SERVICE_PORT)));

    assert_fwd_qualified_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !dec_forward);

endmodule

bind knock_filter knock_filter_checker #(
    .PORT_W       (PORT_W),
    .KNOCK_0      (KNOCK_0),
    .KNOCK_1      (KNOCK_1),
    .KNOCK_2      (KNOCK_2),
    .KNOCK_3      (KNOCK_3),
    .SERVICE_PORT (SERVICE_PORT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pkt_valid    (pkt_valid),
    .pkt_ready    (pkt_ready),
    .pkt_dst_port (pkt_dst_port),
    .dec_valid    (dec_valid),
    .dec_forward  (dec_forward)
);

// File: tb/knock_filter_bench.sv
`timescale 1ns/1ps
module knock_filter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_valid = 1'b0;
    logic        pkt_ready;
    logic [31:0] pkt_src_addr = '0;
    logic [15:0] pkt_dst_port = '0;
    logic        dec_valid;
    logic        dec_forward;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    knock_filter u_knock_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .pkt_valid    (pkt_valid),
        .pkt_ready    (pkt_ready),
        .pkt_src_addr (pkt_src_addr),
        .pkt_dst_port (pkt_dst_port),
        .dec_valid    (dec_valid),
        .dec_forward  (dec_forward)
    );

    // ---------------- behavioural reference model ----------------
    int unsigned m_key [16];
    bit          m_vld [16];
    int          m_st  [16];
    int          m_rr;
    int          knocks [4] = '{5123, 6234, 7345, 8456};

    function automatic void model_reset();
        for (int i = 0; i < 16; i++) begin
            m_vld[i] = 1'b0;
            m_key[i] = 0;
            m_st[i]  = 0;
        end
        m_rr = 0;
    endfunction

    function automatic bit model_step(int unsigned addr, int port);
        int hit = -1;
        int st, nxt, slot;
        bit fwd = 1'b0;
        for (int i = 0; i < 16; i++)
            if (m_vld[i] && m_key[i] == addr) hit = i;
        st = (hit >= 0) ? m_st[hit] : 0;
        if (st == 4) begin
            nxt = 4;
            fwd = (port == 22);
        end else if (port == knocks[st]) begin
            nxt = st + 1;
        end else begin
            nxt = 0;
        end
        if (hit >= 0) begin
            m_st[hit] = nxt;
        end else if (nxt != 0) begin
            slot = -1;
            for (int i = 15; i >= 0; i--)
                if (!m_vld[i]) slot = i;
            if (slot < 0) begin
                slot = m_rr;
                m_rr = (m_rr + 1) % 16;
            end
            m_vld[slot] = 1'b1;
            m_key[slot] = addr;
            m_st[slot]  = nxt;
        end
        return fwd;
    endfunction

    // ---------------- check helper ----------------
    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- expected-verdict pipeline ----------------
    bit    cur_fwd = 1'b0;
    string cur_tag = "R1";
    bit    p1v = 1'b0, p2v = 1'b0, p1f = 1'b0, p2f = 1'b0;
    string p1t = "R1", p2t = "R1";

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p1v = 1'b0;
            p2v = 1'b0;
            p1f = 1'b0;
            p2f = 1'b0;
        end else begin
            p2v = p1v;
            p2f = p1f;
            p2t = p1t;
            p1v = pkt_valid && pkt_ready;
            p1f = cur_fwd;
            p1t = cur_tag;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(dec_valid == p2v, "R1", "dec_valid timing", dec_valid, p2v);
            if (p2v)
                chk(dec_forward == p2f, p2t, "verdict", dec_forward, p2f);
            else
                chk(dec_forward == 1'b0, "R10", "forward while idle", dec_forward, 0);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send(input logic [31:0] a, input int p, input string tag);
        @(negedge clk);
        pkt_valid    = 1'b1;
        pkt_src_addr = a;
        pkt_dst_port = p[15:0];
        cur_fwd      = model_step(a, p);
        cur_tag      = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pkt_valid = 1'b0;
            cur_fwd   = 1'b0;
        end
    endtask

    task automatic knock_all(input logic [31:0] a, input string tag);
        for (int k = 0; k < 4; k++) send(a, knocks[k], tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        pkt_valid = 1'b0;
        rst_n     = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        chk(dec_valid == 1'b0, "R2", "dec_valid in reset", dec_valid, 0);
        chk(pkt_ready == 1'b0, "R2", "pkt_ready in reset", pkt_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pkt_ready == 1'b1, "R1", "pkt_ready after reset", pkt_ready, 1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // ---------------- test sequence ----------------
    initial begin
        do_reset();

        // R6: unknown host is idle, service port dropped
        send(32'h0A00_0001, 22, "R6");
        // R3: full knock sequence, back to back (R9 forwarding)
        knock_all(32'h0A00_0001, "R3");
        // R4: served and held in open
        send(32'h0A00_0001, 22, "R4");
        send(32'h0A00_0001, 80, "R4");
        send(32'h0A00_0001, 5123, "R4");
        send(32'h0A00_0001, 22, "R4");
        idle(3);

        // R5: wrong knock mid-sequence returns to idle, with gaps
        send(32'h0A00_0002, 5123, "R5");
        idle(2);
        send(32'h0A00_0002, 6234, "R5");
        send(32'h0A00_0002, 9999, "R5");
        send(32'h0A00_0002, 7345, "R5");
        send(32'h0A00_0002, 8456, "R5");
        send(32'h0A00_0002, 22, "R5");
        knock_all(32'h0A00_0002, "R9");
        send(32'h0A00_0002, 22, "R9");
        idle(2);

        // R6: two hosts interleaved, independent progress
        for (int k = 0; k < 4; k++) begin
            send(32'h0A00_0003, knocks[k], "R6");
            send(32'h0A00_0004, (k == 2) ? 1234 : knocks[k], "R6");
        end
        send(32'h0A00_0003, 22, "R6");
        send(32'h0A00_0004, 22, "R6");
        idle(3);

        // R7/R8: clean table
        do_reset();
        for (int i = 0; i < 20; i++) send(32'h0B00_0000 + i, 80, "R7");
        for (int i = 0; i < 16; i++) knock_all(32'h0C00_0000 + i, "R7");
        for (int i = 0; i < 16; i++) send(32'h0C00_0000 + i, 22, "R7");
        idle(2);
        // R8: table full, evict entry 0 then 1
        send(32'h0D00_0000, 5123, "R8");
        send(32'h0C00_0000, 22, "R8");
        send(32'h0C00_0001, 22, "R8");
        send(32'h0D00_0001, 5123, "R8");
        idle(1);
        send(32'h0C00_0001, 22, "R8");
        send(32'h0C00_0002, 22, "R8");
        // R9: hit on the entry being evicted one cycle earlier
        send(32'h0D00_0002, 5123, "R9");
        send(32'h0C00_0002, 22, "R9");
        send(32'h0C00_0003, 22, "R9");
        // evicted host rebuilds its state in a fresh entry
        knock_all(32'h0C00_0002, "R8");
        send(32'h0C00_0002, 22, "R8");
        idle(4);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule